// File: doc/BRIEF.md
# Converter Calibration Command Sequencer

This block controls calibration for an oversampling analog-to-digital converter. A host holds the calibration request line high. On the first clock that sees the request high, the block captures the two type-select inputs. When the request line drops, it starts the chosen calibration step, but only if the line was held high long enough. A step lasts for a fixed number of master-clock cycles. Each calibration type has its own budget. During the step a busy flag stays high. When the step ends, the block issues an override command to the output register: pass normal data through, force the word to all zeros, or force it to all ones.

The block also enforces the two-step system calibration order: an offset step must finish before a gain step is allowed. A gain request that arrives too early is dropped and recorded in a sticky sequence-error flag. A calibrated status bit reports that a usable calibration exists. A change on the polarity-select input clears it.

The coefficient arithmetic is outside this block. Completion is modelled only as cycle counting. Each budget equals its nominal cycle count divided by the integer parameter `SCALE`, with a minimum of one cycle. This lets a short simulation check the relative durations exactly. All pins are plain control and status signals, so there is no valid/ready handshake.

Top module: `cal_seq_top`

## Requirements
- R1: A request counts only if `cal_req` is seen high on at least `MIN_HIGH` rising clock edges (default 4) before the first edge that sees it low. A shorter pulse starts nothing.
- R2: The type is taken as {`type_a`,`type_b`} on the first edge that sees `cal_req` high. Later changes to the type inputs during that pulse have no effect.
- R3: Type encoding and budgets, with each count divided by `SCALE` (minimum 1):
  - 2'b00: self calibration, 3145655 cycles.
  - 2'b11: system offset step, 1052599 cycles.
  - 2'b01: system gain step, 1068813 cycles.
  - 2'b10: offset step with the reference as full scale, 2117389 cycles.
- R4: Let edge k be the first edge that sees `cal_req` low after a qualified request. `busy` rises after edge k+1 and stays high for exactly the budget of the step.
- R5: A request that completes while `busy` is high is ignored. The running step keeps its length, and no second step follows.
- R6: A gain request is accepted only after a system offset step (2'b11) has finished with no later self calibration or polarity change. Otherwise it is ignored: `busy` stays low and `seq_err` is set. `seq_err` stays set until reset.
- R7: `ovr_code` is 0 (normal data) when a step starts. When a step ends, it becomes 1 (all zeros) after either offset type, 2 (all ones) after a gain step, and 0 after self calibration. It changes at no other time.
- R8: `calibrated` is set when a self calibration or a gain step finishes. Offset-only steps leave it unchanged.
- R9: A change of `bipolar` clears `calibrated` on the next edge and cancels a completed offset step. If the change happens while a step runs, that step does not set `calibrated`.
- R10: After a full offset-then-gain sequence, further offset steps and gain steps may each be run on their own.
- R11: After reset, `busy`, `seq_err` and `calibrated` are 0 and `ovr_code` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_req | input | 1 | Calibration request; the step starts when it falls |
| type_a | input | 1 | Type select, upper bit |
| type_b | input | 1 | Type select, lower bit |
| bipolar | input | 1 | Polarity range select; any change invalidates calibration |
| busy | output | 1 | High while a calibration step runs |
| ovr_code | output | 2 | Output-register override: 0 pass, 1 zeros, 2 ones |
| seq_err | output | 1 | Sticky flag for a gain request made out of order |
| calibrated | output | 1 | A valid calibration exists for the current polarity |

## Verification
The hardest conditions to create are those that must overlap a step already running. These are a second qualified request that falls while `busy` is high, and a polarity change in the middle of a self calibration. The bench gets there from inside its step-measuring loop: it counts `busy` cycles and drives the request pulse or the polarity flip at a chosen count. It still checks the exact run length and the final status. Request-width qualification is swept over pulse widths 1 to 6, and every type is timed against its scaled budget.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;
  // {type_a, type_b} encoding
  typedef enum logic [1:0] {
    CK_SELF   = 2'b00,
    CK_GAIN   = 2'b01,
    CK_REFOFF = 2'b10,
    CK_OFFSET = 2'b11
  } cal_kind_e;

  typedef enum logic [1:0] {
    OV_PASS  = 2'b00,
    OV_ZEROS = 2'b01,
    OV_ONES  = 2'b10
  } ovr_e;

  typedef struct packed {
    logic      vld;
    cal_kind_e kind;
  } cal_cmd_t;

  function automatic int scaled_len(input int cycles, input int scale);
    return (cycles / scale < 1) ? 1 : cycles / scale;
  endfunction
endpackage

// File: rtl/cal_req_qual.sv
module cal_req_qual
  import cal_seq_pkg::*;
#(
  parameter int MIN_HIGH = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cal_req,
  input  logic     type_a,
  input  logic     type_b,
  output cal_cmd_t cmd
);
  localparam int HW = $clog2(MIN_HIGH + 1);

  logic          req_q;
  logic [HW-1:0] hi_cnt;
  cal_kind_e     kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      hi_cnt   <= '0;
      kind_q   <= CK_SELF;
      cmd      <= '{vld: 1'b0, kind: CK_SELF};
    end else begin
      req_q   <= cal_req;
      cmd.vld <= 1'b0;
      if (cal_req && !req_q) begin
        kind_q <= cal_kind_e'({type_a, type_b});
        hi_cnt <= HW'(1);
      end else if (cal_req && hi_cnt != HW'(MIN_HIGH)) begin
        hi_cnt <= hi_cnt + HW'(1);
      end
      if (!cal_req && req_q) begin
        cmd.vld  <= (hi_cnt >= HW'(MIN_HIGH));
        cmd.kind <= kind_q;
        hi_cnt   <= '0;
      end
    end
  end
endmodule

// File: rtl/cal_step_timer.sv
module cal_step_timer
  import cal_seq_pkg::*;
#(
  parameter int SCALE      = 1,
  parameter int CYC_SELF   = 3145655,
  parameter int CYC_OFFSET = 1052599,
  parameter int CYC_GAIN   = 1068813,
  parameter int CYC_REFOFF = 2117389
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  cal_kind_e kind,
  output logic      busy,
  output logic      done,
  output cal_kind_e done_kind
);
  localparam int L_SELF   = scaled_len(CYC_SELF, SCALE);
  localparam int L_OFFSET = scaled_len(CYC_OFFSET, SCALE);
  localparam int L_GAIN   = scaled_len(CYC_GAIN, SCALE);
  localparam int L_REFOFF = scaled_len(CYC_REFOFF, SCALE);
  localparam int L_MAX01  = (L_SELF > L_OFFSET) ? L_SELF : L_OFFSET;
  localparam int L_MAX23  = (L_GAIN > L_REFOFF) ? L_GAIN : L_REFOFF;
  localparam int L_MAX    = (L_MAX01 > L_MAX23) ? L_MAX01 : L_MAX23;
  localparam int CW       = $clog2(L_MAX + 1);

  logic [CW-1:0] remain;
  logic [CW-1:0] load_val;

  always_comb begin
    unique case (kind)
      CK_SELF:   load_val = CW'(L_SELF - 1);
      CK_OFFSET: load_val = CW'(L_OFFSET - 1);
      CK_GAIN:   load_val = CW'(L_GAIN - 1);
      default:   load_val = CW'(L_REFOFF - 1);
    endcase
  end

  assign done = busy && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      remain    <= '0;
      done_kind <= CK_SELF;
    end else if (start && !busy) begin
      busy      <= 1'b1;
      remain    <= load_val;
      done_kind <= kind;
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      remain <= remain - CW'(1);
    end
  end
endmodule

// File: rtl/cal_seq_track.sv
module cal_seq_track
  import cal_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cal_cmd_t   cmd,
  input  logic       busy,
  input  logic       done,
  input  cal_kind_e  done_kind,
  input  logic       bipolar,
  output logic       start,
  output logic       seq_err,
  output logic       calibrated,
  output logic [1:0] ovr_code
);
  logic off_done;
  logic bip_q;
  logic stale;
  logic gain_drop;
  logic mode_chg;
  ovr_e ovr_q;

  assign start     = cmd.vld && !busy && (cmd.kind != CK_GAIN || off_done);
  assign gain_drop = cmd.vld && !busy && cmd.kind == CK_GAIN && !off_done;
  assign mode_chg  = bipolar != bip_q;
  assign ovr_code  = ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_done   <= 1'b0;
      bip_q      <= bipolar;
      stale      <= 1'b0;
      seq_err    <= 1'b0;
      calibrated <= 1'b0;
      ovr_q      <= OV_PASS;
    end else begin
      bip_q <= bipolar;
      if (gain_drop) seq_err <= 1'b1;
      if (start) begin
        ovr_q <= OV_PASS;
        stale <= 1'b0;
      end
      if (done) begin
        unique case (done_kind)
          CK_SELF: begin
            ovr_q      <= OV_PASS;
            off_done   <= 1'b0;
            calibrated <= !stale;
          end
          CK_OFFSET: begin
            ovr_q    <= OV_ZEROS;
            off_done <= !stale;
          end
          CK_GAIN: begin
            ovr_q      <= OV_ONES;
            calibrated <= !stale;
          end
          default: ovr_q <= OV_ZEROS;
        endcase
      end
      if (mode_chg) begin
        calibrated <= 1'b0;
        off_done   <= 1'b0;
        if (busy && !done) stale <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cal_seq_top.sv
module cal_seq_top
  import cal_seq_pkg::*;
#(
  parameter int SCALE      = 1,
  parameter int MIN_HIGH   = 4,
  parameter int CYC_SELF   = 3145655,
  parameter int CYC_OFFSET = 1052599,
  parameter int CYC_GAIN   = 1068813,
  parameter int CYC_REFOFF = 2117389
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cal_req,
  input  logic       type_a,
  input  logic       type_b,
  input  logic       bipolar,
  output logic       busy,
  output logic [1:0] ovr_code,
  output logic       seq_err,
  output logic       calibrated
);
  cal_cmd_t  cmd;
  logic      start;
  logic      done;
  cal_kind_e done_kind;

  cal_req_qual #(.MIN_HIGH(MIN_HIGH)) u_qual (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req),
    .type_a(type_a), .type_b(type_b), .cmd(cmd)
  );

  cal_step_timer #(
    .SCALE(SCALE), .CYC_SELF(CYC_SELF), .CYC_OFFSET(CYC_OFFSET),
    .CYC_GAIN(CYC_GAIN), .CYC_REFOFF(CYC_REFOFF)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(cmd.kind),
    .busy(busy), .done(done), .done_kind(done_kind)
  );

  cal_seq_track u_track (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .busy(busy), .done(done),
    .done_kind(done_kind), .bipolar(bipolar), .start(start),
    .seq_err(seq_err), .calibrated(calibrated), .ovr_code(ovr_code)
  );
endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk
  import cal_seq_pkg::*;
#(
  parameter int SCALE      = 1,
  parameter int CYC_SELF   = 3145655,
  parameter int CYC_OFFSET = 1052599,
  parameter int CYC_GAIN   = 1068813,
  parameter int CYC_REFOFF = 2117389
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cal_req,
  input logic       bipolar,
  input logic       busy,
  input logic [1:0] ovr_code,
  input logic       seq_err,
  input logic       calibrated
);
  localparam int M1   = (scaled_len(CYC_SELF, SCALE) > scaled_len(CYC_OFFSET, SCALE)) ?
                        scaled_len(CYC_SELF, SCALE) : scaled_len(CYC_OFFSET, SCALE);
  localparam int M2   = (scaled_len(CYC_GAIN, SCALE) > scaled_len(CYC_REFOFF, SCALE)) ?
                        scaled_len(CYC_GAIN, SCALE) : scaled_len(CYC_REFOFF, SCALE);
  localparam int LMAX = (M1 > M2) ? M1 : M2;

  int unsigned run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  // R4
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= LMAX);

  // R1
  start_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!$past(cal_req, 2) && $past(cal_req, 3)));

  // R6
  seq_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);

  // R7
  ovr_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ovr_code == 2'b00);

  // R7
  ovr_moves_at_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_code != $past(ovr_code)) |-> ($rose(busy) || $fell(busy)));

  // R8
  cal_set_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(calibrated) |-> $fell(busy));

  // R9
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bipolar != $past(bipolar)) |=> !calibrated);
endmodule

bind cal_seq_top cal_seq_chk #(
  .SCALE(SCALE), .CYC_SELF(CYC_SELF), .CYC_OFFSET(CYC_OFFSET),
  .CYC_GAIN(CYC_GAIN), .CYC_REFOFF(CYC_REFOFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .bipolar(bipolar),
  .busy(busy), .ovr_code(ovr_code), .seq_err(seq_err), .calibrated(calibrated)
);

// File: tb/tb_cal_seq_top.sv
`timescale 1ns/1ps
module tb_cal_seq_top;
  localparam int SC = 1024;
  localparam int E_SELF   = (3145655 / SC < 1) ? 1 : 3145655 / SC;
  localparam int E_OFFSET = (1052599 / SC < 1) ? 1 : 1052599 / SC;
  localparam int E_GAIN   = (1068813 / SC < 1) ? 1 : 1068813 / SC;
  localparam int E_REFOFF = (2117389 / SC < 1) ? 1 : 2117389 / SC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_req = 1'b0, type_a = 1'b0, type_b = 1'b0, bipolar = 1'b0;
  logic busy, seq_err, calibrated;
  logic [1:0] ovr_code;
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  cal_seq_top #(.SCALE(SC)) dut (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .type_a(type_a),
    .type_b(type_b), .bipolar(bipolar), .busy(busy), .ovr_code(ovr_code),
    .seq_err(seq_err), .calibrated(calibrated)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drives one request and measures the resulting step.
  task automatic run(input logic s1, input logic s2, input int h, input bit swap,
                     input bit exp_run, input int exp_len, input bit inject,
                     input bit flip_bip, input string tag);
    int n;
    int seen;
    @(negedge clk);
    type_a = s1; type_b = s2; cal_req = 1'b1;
    for (int i = 0; i < h; i++) begin
      @(negedge clk);
      if (swap && i == 0) begin type_a = ~s1; type_b = ~s2; end
    end
    cal_req = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R4", busy, 0);
    @(negedge clk);
    if (!exp_run) begin
      seen = 0;
      for (int i = 0; i < 8; i++) begin
        if (busy) seen++;
        @(negedge clk);
      end
      chk(seen == 0, tag, seen, 0);
    end else begin
      chk(busy == 1'b1, "R4", busy, 1);
      n = 0;
      while (busy && n < exp_len + 10) begin
        if (inject && n == 10) cal_req = 1'b1;
        if (inject && n == 16) cal_req = 1'b0;
        if (flip_bip && n == 20) bipolar = ~bipolar;
        n++;
        @(negedge clk);
      end
      chk(n == exp_len, tag, n, exp_len);
      seen = 0;
      for (int i = 0; i < 6; i++) begin
        if (busy) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R5", seen, 0);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(busy == 0 && seq_err == 0 && calibrated == 0 && ovr_code == 0, "R11",
        {busy, seq_err, calibrated, ovr_code}, 0);

    // R1 short pulse starts nothing
    run(1'b0, 1'b0, 3, 0, 0, 0, 0, 0, "R1");
    // R6 gain before offset is dropped and flagged
    run(1'b0, 1'b1, 4, 0, 0, 0, 0, 0, "R6");
    chk(seq_err == 1, "R6", seq_err, 1);
    chk(ovr_code == 0, "R6", ovr_code, 0);
    // R3 self calibration
    run(1'b0, 1'b0, 4, 0, 1, E_SELF, 0, 0, "R3");
    chk(ovr_code == 0, "R7", ovr_code, 0);
    chk(calibrated == 1, "R8", calibrated, 1);
    // R2 type swapped after rise; R5 request during run
    run(1'b1, 1'b1, 5, 1, 1, E_OFFSET, 1, 0, "R2");
    chk(ovr_code == 1, "R7", ovr_code, 1);
    chk(calibrated == 1, "R8", calibrated, 1);
    // gain after offset
    run(1'b0, 1'b1, 4, 0, 1, E_GAIN, 0, 0, "R3");
    chk(ovr_code == 2, "R7", ovr_code, 2);
    chk(calibrated == 1, "R8", calibrated, 1);
    // R10 repeat offset, then gain again
    run(1'b1, 1'b1, 4, 0, 1, E_OFFSET, 0, 0, "R10");
    run(1'b0, 1'b1, 4, 0, 1, E_GAIN, 0, 0, "R10");
    // reference-based offset
    run(1'b1, 1'b0, 4, 0, 1, E_REFOFF, 0, 0, "R3");
    chk(ovr_code == 1, "R7", ovr_code, 1);
    // R9 polarity change clears status and cancels offset
    @(negedge clk); bipolar = 1'b1;
    @(negedge clk);
    chk(calibrated == 0, "R9", calibrated, 0);
    run(1'b0, 1'b1, 4, 0, 0, 0, 0, 0, "R9");
    chk(ovr_code == 1, "R9", ovr_code, 1);
    // R8 offset alone does not set calibrated
    run(1'b1, 1'b1, 4, 0, 1, E_OFFSET, 0, 0, "R3");
    chk(calibrated == 0, "R8", calibrated, 0);
    run(1'b0, 1'b1, 4, 0, 1, E_GAIN, 0, 0, "R3");
    chk(calibrated == 1, "R8", calibrated, 1);
    // R9 polarity flip during a self calibration
    run(1'b0, 1'b0, 4, 0, 1, E_SELF, 0, 1, "R3");
    chk(calibrated == 0, "R9", calibrated, 0);
    run(1'b0, 1'b0, 4, 0, 1, E_SELF, 0, 0, "R3");
    chk(calibrated == 1, "R8", calibrated, 1);
    // R6 self calibration cancels an earlier offset
    run(1'b0, 1'b1, 4, 0, 0, 0, 0, 0, "R6");
    // R1 width sweep
    for (int h = 1; h <= 6; h++)
      run(1'b1, 1'b0, h, 0, (h >= 4), E_REFOFF, 0, 0, "R1");
    chk(seq_err == 1, "R6", seq_err, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule